// File: doc/BRIEF.md
# Serial Command Front End for an Eight-Channel Converter

This block takes a serial command stream framed by an active-low chip-select. While the select is low, each rising edge of the serial clock shifts one data bit into a 32-bit shift register. When the select returns high, the block decodes the most recent 24 bits as a command, a channel address and a 16-bit code. It then acts on a set of double-buffered channel registers. Each channel has a staging register, an active register and a power-down flag. The active codes and the power-down flags drive the converter cores.

The serial pins are oversampled in the system clock domain through two-stage synchronizers. Edges of the serial clock and of the select are detected in that domain. A frame of 32 bits places eight filler bits ahead of the 24-bit word, and those filler bits are ignored. A frame of fewer than 24 bits does nothing. The serial output carries the shift register's oldest bit, which lets several devices be chained. An active-low clear input, asynchronous and level-sensitive, returns every register to zero, as the reset does.

Top module: `dac_serial_frontend`

## Requirements
- R1: Bits shift in, MSB first, only on rising serial-clock edges while cs_n is low. Serial-clock edges while cs_n is high change nothing.
- R2: On the rise of cs_n, the last 24 bits shifted in are decoded: bits 23:20 are the command, bits 19:16 the address, bits 15:0 the code. In a 32-bit frame the first 8 bits have no effect.
- R3: Command 0000 loads the code into the staging register of the addressed channel and leaves the outputs unchanged. Command 0001 copies the staging register to the active output and clears that channel's power-down flag.
- R4: Command 0010 loads the staging register of the addressed channel. It then copies every channel's staging register to its active output and clears all power-down flags.
- R5: Command 0011 loads both the staging and the active register of the addressed channel and clears its power-down flag.
- R6: Command 0100 sets the power-down flag of the addressed channel and leaves the codes unchanged.
- R7: Addresses 0000 to 0111 select channels 0 to 7. Channel i drives codes[16*i+15:16*i] and pd[i]. Address 1111 selects all channels.
- R8: Command 1111, any other command code, and any address from 1000 to 1110 leave all registers unchanged.
- R9: A frame in which fewer than 24 bits were clocked is discarded.
- R10: Each rise of cs_n applies the command at most once. A select pulse with no serial-clock edges executes nothing.
- R11: sdo shows the bit shifted in 32 rising edges earlier. It changes only after a falling serial-clock edge and stays driven while cs_n is high.
- R12: rst_n or clr_n low asynchronously clears the codes, the power-down flags, the staging registers, the shift register and sdo.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous power-on reset |
| clr_n | input | 1 | Active-low asynchronous clear |
| cs_n | input | 1 | Frame select, active low |
| sck | input | 1 | Serial clock |
| sdi | input | 1 | Serial data in |
| sdo | output | 1 | Serial data out for chaining |
| codes | output | 128 | Active codes, channel i at bits 16*i+15:16*i |
| pd | output | 8 | Power-down flag per channel |

## Verification
Embedded assertions check several properties on every cycle. The shift register holds while the select is idle high. sdo moves only after a detected serial-clock fall. A short frame and an unknown command leave the outputs unchanged. Broadcast power-down sets every flag, and command 0010 clears them all. The bench scenarios cover the rest. These are the double-buffer sequencing across separate frames, the decoding of 32-bit frames with filler bits, and the 32-edge lag of sdo across frame boundaries. They also include a clear asserted between clock edges, and mixed random command streams compared against a channel model.

// File: rtl/dac_serial_frontend.sv
module dac_serial_frontend #(
  parameter int NCH = 8,
  parameter int DW  = 16,
  parameter int FW  = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr_n,
  input  logic              cs_n,
  input  logic              sck,
  input  logic              sdi,
  output logic              sdo,
  output logic [NCH*DW-1:0] codes,
  output logic [NCH-1:0]    pd
);
  localparam int MINB = DW + 8;
  localparam int CW   = $clog2(FW + 1);

  logic arst_n;
  assign arst_n = rst_n & clr_n;

  logic [2:0] sck_s, cs_s;
  logic [1:0] sdi_s;

  always_ff @(posedge clk or negedge arst_n)
    if (!arst_n) begin
      sck_s <= '0;
      cs_s  <= '1;
      sdi_s <= '0;
    end else begin
      sck_s <= {sck_s[1:0], sck};
      cs_s  <= {cs_s[1:0], cs_n};
      sdi_s <= {sdi_s[0], sdi};
    end

  logic sck_rise, sck_fall, cs_rise, cs_fall, sel;
  assign sck_rise = sck_s[1] & ~sck_s[2];
  assign sck_fall = ~sck_s[1] & sck_s[2];
  assign cs_rise  = cs_s[1] & ~cs_s[2];
  assign cs_fall  = ~cs_s[1] & cs_s[2];
  assign sel      = ~cs_s[1];

  logic [FW-1:0] sr;
  logic [CW-1:0] cnt;
  logic          sdo_q;

  always_ff @(posedge clk or negedge arst_n)
    if (!arst_n) begin
      sr    <= '0;
      cnt   <= '0;
      sdo_q <= 1'b0;
    end else begin
      if (cs_fall) cnt <= '0;
      else if (sel && sck_rise && cnt != CW'(FW)) cnt <= cnt + 1'b1;
      if (sel && sck_rise) sr <= {sr[FW-2:0], sdi_s[1]};
      if (sck_fall) sdo_q <= sr[FW-1];
    end

  assign sdo = sdo_q;

  logic [3:0]    cmd, adr;
  logic [DW-1:0] dat;
  logic          exec, adr_ok;
  assign cmd    = sr[DW+7:DW+4];
  assign adr    = sr[DW+3:DW];
  assign dat    = sr[DW-1:0];
  assign exec   = cs_rise && (cnt >= CW'(MINB));
  assign adr_ok = (adr < 4'(NCH)) || (adr == 4'hF);

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    logic [DW-1:0] in_r, act_r;
    logic          pd_r, hit;
    assign hit = (adr == 4'(i)) || (adr == 4'hF);

    always_ff @(posedge clk or negedge arst_n)
      if (!arst_n) begin
        in_r  <= '0;
        act_r <= '0;
        pd_r  <= 1'b0;
      end else if (exec && adr_ok) begin
        case (cmd)
          4'b0000: if (hit) in_r <= dat;
          4'b0001: if (hit) begin act_r <= in_r; pd_r <= 1'b0; end
          4'b0010: begin
            if (hit) in_r <= dat;
            act_r <= hit ? dat : in_r;
            pd_r  <= 1'b0;
          end
          4'b0011: if (hit) begin in_r <= dat; act_r <= dat; pd_r <= 1'b0; end
          4'b0100: if (hit) pd_r <= 1'b1;
          default: ;
        endcase
      end

    assign codes[i*DW +: DW] = act_r;
    assign pd[i]             = pd_r;
  end

  p_cs_idle_hold_r1: assert property (@(posedge clk) disable iff (!arst_n)
    (cs_s[1] && cs_s[2]) |=> $stable(sr));

  p_sdo_on_fall_r11: assert property (@(posedge clk) disable iff (!arst_n)
    !sck_fall |=> $stable(sdo));

  p_short_drop_r9: assert property (@(posedge clk) disable iff (!arst_n)
    (cs_rise && cnt < CW'(MINB)) |=> ($stable(codes) && $stable(pd)));

  p_upd_all_r4: assert property (@(posedge clk) disable iff (!arst_n)
    (exec && cmd == 4'b0010 && adr_ok) |=> (pd == '0));

  p_pd_all_r6: assert property (@(posedge clk) disable iff (!arst_n)
    (exec && cmd == 4'b0100 && adr == 4'hF) |=> ((&pd) && $stable(codes)));

  p_nop_r8: assert property (@(posedge clk) disable iff (!arst_n)
    (cs_rise && (cmd > 4'b0100 || !adr_ok)) |=> ($stable(codes) && $stable(pd)));

  p_cnt_bound_r10: assert property (@(posedge clk) disable iff (!arst_n)
    cnt <= CW'(FW));
endmodule

// File: tb/dac_serial_frontend_tb.sv
module dac_serial_frontend_tb;
  logic clk = 0, rst_n = 0, clr_n = 1, cs_n = 1, sck = 0, sdi = 0;
  logic sdo;
  logic [127:0] codes;
  logic [7:0] pd;

  dac_serial_frontend u_dut (.clk(clk), .rst_n(rst_n), .clr_n(clr_n), .cs_n(cs_n),
    .sck(sck), .sdi(sdi), .sdo(sdo), .codes(codes), .pd(pd));

  always #5 clk = ~clk;

  int checks = 0, fails = 0;
  logic [15:0] m_in [8];
  logic [15:0] m_act [8];
  logic [7:0]  m_pd;
  logic [31:0] m_sr;
  bit sdo_bad;

  function automatic logic [127:0] exp_codes();
    logic [127:0] v;
    for (int i = 0; i < 8; i++) v[i*16 +: 16] = m_act[i];
    return v;
  endfunction

  task automatic model_clear();
    for (int i = 0; i < 8; i++) begin m_in[i] = '0; m_act[i] = '0; end
    m_pd = '0; m_sr = '0;
  endtask

  task automatic model_apply(logic [23:0] w);
    logic [3:0] c, a; logic [15:0] d;
    c = w[23:20]; a = w[19:16]; d = w[15:0];
    if (!(a < 8 || a == 4'hF)) return;
    for (int i = 0; i < 8; i++) begin
      bit h; h = (a == 4'(i)) || (a == 4'hF);
      case (c)
        4'h0: if (h) m_in[i] = d;
        4'h1: if (h) begin m_act[i] = m_in[i]; m_pd[i] = 0; end
        4'h2: begin if (h) m_in[i] = d; m_act[i] = m_in[i]; m_pd[i] = 0; end
        4'h3: if (h) begin m_in[i] = d; m_act[i] = d; m_pd[i] = 0; end
        4'h4: if (h) m_pd[i] = 1;
        default: ;
      endcase
    end
  endtask

  task automatic check(string req, logic [135:0] act, logic [135:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic check_out(string req);
    check(req, {pd, codes}, {m_pd, exp_codes()});
  endtask

  task automatic wclk(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic send(int nbits, logic [31:0] w);
    sdo_bad = 0;
    cs_n = 0; wclk(4);
    for (int b = nbits - 1; b >= 0; b--) begin
      sdi = w[b]; wclk(4);
      sck = 1; m_sr = {m_sr[30:0], w[b]}; wclk(4);
      sck = 0; wclk(4);
      if (sdo !== m_sr[31]) sdo_bad = 1;
    end
    wclk(4); cs_n = 1; wclk(8);
    if (nbits >= 24) model_apply(w[23:0]);
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog actual=timeout expected=done");
    finish_run();
  end

  initial begin
    void'($urandom(32'd20240611));
    model_clear();
    wclk(3); rst_n = 1; wclk(4);
    check("R12 reset state", {pd, codes}, '0);
    check("R12 reset sdo", 136'(sdo), 136'(0));

    send(24, {8'h0, 4'h0, 4'h2, 16'hA5C3});
    check_out("R3 write leaves outputs");
    send(24, {8'h0, 4'h1, 4'h2, 16'h0000});
    check_out("R3 update copies staging");
    check("R3 channel 2 code", 136'(codes[47:32]), 136'(16'hA5C3));

    send(24, {8'h0, 4'h4, 4'hF, 16'h1234});
    check_out("R6 broadcast power-down");
    check("R7 all flags set", 136'(pd), 136'(8'hFF));
    send(24, {8'h0, 4'h2, 4'h5, 16'h7777});
    check_out("R4 write n update all");
    check("R4 flags cleared", 136'(pd), 136'(0));

    send(32, {8'hF3, 4'h3, 4'h7, 16'hBEEF});
    check_out("R2 R5 32-bit frame write+update");
    check("R5 channel 7 code", 136'(codes[127:112]), 136'(16'hBEEF));
    check("R11 sdo lag over frame", 136'(sdo_bad), 136'(0));

    send(16, {16'h0, 16'h3F00});
    check_out("R9 short frame discarded");

    send(24, {8'h0, 4'h5, 4'h1, 16'hFFFF});
    check_out("R8 reserved command");
    send(24, {8'h0, 4'h3, 4'h9, 16'hFFFF});
    check_out("R8 reserved address");
    send(24, {8'h0, 4'hF, 4'h3, 16'hFFFF});
    check_out("R8 no operation");

    for (int k = 0; k < 6; k++) begin
      sdi = 1; wclk(4); sck = 1; wclk(4); sck = 0; wclk(4);
    end
    check("R1 R11 sck ignored while idle, sdo driven", 136'(sdo), 136'(m_sr[31]));
    send(24, {8'h0, 4'h3, 4'h0, 16'h0F0F});
    check_out("R1 frame after idle clocks");

    cs_n = 0; wclk(6); cs_n = 1; wclk(8);
    check_out("R10 select pulse without clocks");

    @(posedge clk); #2 clr_n = 0; #1;
    model_clear();
    check("R12 asynchronous clear", {pd, codes, 8'(sdo)}, '0);
    wclk(2); clr_n = 1; wclk(4);

    for (int k = 0; k < 120; k++) begin
      logic [3:0] c, a; logic [31:0] w; int n, r;
      r = $urandom_range(0, 9);
      c = (r < 6) ? 4'(r) : (r == 6 ? 4'hF : (r == 7 ? 4'h4 : 4'h3));
      if (r == 9) c = 4'h9;
      r = $urandom_range(0, 11);
      a = (r < 8) ? 4'(r) : (r < 10 ? 4'hF : 4'hC);
      w = {8'($urandom), c, a, 16'($urandom)};
      r = $urandom_range(0, 9);
      n = (r < 5) ? 24 : (r < 8 ? 32 : (r == 8 ? 28 : 20));
      send(n, w);
      check_out("R7 random command stream");
      check("R11 random sdo lag", 136'(sdo_bad), 136'(0));
    end
    finish_run();
  end
endmodule